// File: doc/BRIEF.md
# Shift-Register Return Address Stack

This block keeps return addresses for a small processor core. It holds them in a fixed chain of registers instead of RAM. A subroutine call or an interrupt entry pushes the address to return to. A plain return or a return from interrupt pops it. Both kinds of event use the same stack, so the core drives one push strobe and one pop strobe for all of them.

The stack has no pointer. A push moves every level one step deeper, and a pop moves every level one step toward the top. When more entries are pushed than the stack has levels, the oldest entry falls off the bottom and no error is signalled. On a pop, the deepest level keeps its value. Pops beyond the number of stored entries therefore keep returning that deepest value.

The top entry is always visible on an output. The core can read its return address in the same cycle that it raises the pop strobe.

Top module: `ret_addr_stack`

## Requirements
- R1: An active-low asynchronous reset clears all three levels to zero. After reset, top_o reads 0 and every pop returns 0.
- R2: top_o shows level 0 combinationally. During a cycle with pop_i high, top_o already shows the address being returned, before the clock edge.
- R3: A push alone (push_i=1, pop_i=0) works as follows at the rising edge:
  - push_addr_i is written into level 0;
  - the old level 0 moves to level 1;
  - the old level 1 moves to level 2;
  - the old level 2 is lost, with no indication.
- R4: A pop alone (pop_i=1, push_i=0) moves level 1 into level 0 and level 2 into level 1 at the rising edge.
- R5: On a pop, level 2 keeps its value. Pops after the stack has emptied return the deepest value again and again.
- R6: Pushing A1, A2, A3, A4 and then popping four times returns A4, A3, A2, A2.
- R7: With push_i and pop_i both high, level 0 takes push_addr_i and levels 1 and 2 stay unchanged.
- R8: With neither strobe high, all levels hold, and push_addr_i has no effect.
- R9: Each level stores a full 9-bit address. The values 0x000 and 0x1FF are returned unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push strobe (call or interrupt entry) |
| pop_i | input | 1 | Pop strobe (return or return from interrupt) |
| push_addr_i | input | 9 | Return address to push |
| top_o | output | 9 | Current level 0 (return address) |

## Verification
A directed sequence of four pushes and four pops shows that the oldest entry is lost and that the deepest value repeats. A bench that forgot the deepest level would miss this case. Pops right after reset show the cleared state. Cycles with both strobes high show that a combined operation replaces only the top and does not shift. Idle cycles with push_addr_i changing show that the stack holds. A long fixed-seed random mix of push, pop, combined and idle cycles, compared against a three-entry bench model, covers operations back to back in every order. The all-zero and all-one addresses confirm that all nine bits are stored.

// File: rtl/rstk_pkg.sv
package rstk_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_SWAP = 2'b11   // push and pop together: replace top only
  } stk_op_e;
endpackage

// File: rtl/rstk_op_decode.sv
module rstk_op_decode
  import rstk_pkg::*;
(
  input  logic    push_i,
  input  logic    pop_i,
  output stk_op_e op_o
);
  always_comb begin
    unique case ({pop_i, push_i})
      2'b01:   op_o = OP_PUSH;
      2'b10:   op_o = OP_POP;
      2'b11:   op_o = OP_SWAP;
      default: op_o = OP_HOLD;
    endcase
  end
endmodule

// File: rtl/rstk_level.sv
module rstk_level
  import rstk_pkg::*;
#(
  parameter int unsigned AW     = 9,
  parameter bit          IS_TOP = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  stk_op_e       op_i,
  input  logic [AW-1:0] from_above_i,  // new address for the top level
  input  logic [AW-1:0] from_below_i,  // own value for the deepest level
  output logic [AW-1:0] q_o
);
  logic [AW-1:0] d;

  always_comb begin
    d = q_o;
    unique case (op_i)
      OP_PUSH: d = from_above_i;
      OP_POP:  d = from_below_i;
      OP_SWAP: if (IS_TOP) d = from_above_i;
      default: d = q_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d;
  end
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
  import rstk_pkg::*;
#(
  parameter int unsigned AW    = 9,
  parameter int unsigned DEPTH = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] push_addr_i,
  output logic [AW-1:0] top_o
);
  localparam int unsigned LAST = DEPTH - 1;

  stk_op_e       op;
  logic [AW-1:0] lvl_q [DEPTH];

  rstk_op_decode u_dec (
    .push_i (push_i),
    .pop_i  (pop_i),
    .op_o   (op)
  );

  for (genvar k = 0; k < DEPTH; k++) begin : g_lvl
    logic [AW-1:0] above, below;
    if (k == 0) begin : g_a0
      assign above = push_addr_i;
    end else begin : g_an
      assign above = lvl_q[k-1];
    end
    if (k == LAST) begin : g_bl
      assign below = lvl_q[k];      // deepest level copies itself upward
    end else begin : g_bn
      assign below = lvl_q[k+1];
    end

    rstk_level #(.AW(AW), .IS_TOP(k == 0)) u_level (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .op_i         (op),
      .from_above_i (above),
      .from_below_i (below),
      .q_o          (lvl_q[k])
    );

    if (k > 0) begin : g_sa
      a_r3_push_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && !pop_i) |=> lvl_q[k] == $past(lvl_q[k-1]));
      a_r7_swap_keeps_lower: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && pop_i) |=> $stable(lvl_q[k]));
    end
    if (k < LAST) begin : g_sp
      a_r4_pop_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pop_i && !push_i) |=> lvl_q[k] == $past(lvl_q[k+1]));
    end
    a_r8_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!push_i && !pop_i) |=> $stable(lvl_q[k]));
  end

  assign top_o = lvl_q[0];

  a_r3_push_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> top_o == $past(push_addr_i));
  a_r5_deepest_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> $stable(lvl_q[LAST]));
endmodule

// File: tb/ret_addr_stack_tb.sv
`timescale 1ns/1ps
module ret_addr_stack_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       push_i = 1'b0, pop_i = 1'b0;
  logic [8:0] push_addr_i = '0;
  logic [8:0] top_o;

  int checks = 0, errors = 0;
  logic [8:0] m [3];

  ret_addr_stack u_dut (.*);

  always #4 clk_i = ~clk_i;  // 125 MHz

  task automatic check(input bit ok, input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void model_step(input bit pu, input bit po, input logic [8:0] a);
    if (pu && po) m[0] = a;
    else if (pu) begin m[2] = m[1]; m[1] = m[0]; m[0] = a; end
    else if (po) begin m[0] = m[1]; m[1] = m[2]; end
  endfunction

  // drive at negedge, check top before edge if popping, then after edge
  task automatic op(input bit pu, input bit po, input logic [8:0] a, input string req);
    @(negedge clk_i);
    push_i = pu; pop_i = po; push_addr_i = a;
    #1;
    if (po) check(top_o === m[0], {req, "/R2 pre-edge top"}, top_o, m[0]);
    model_step(pu, po, a);
    @(negedge clk_i);
    push_i = 0; pop_i = 0;
    check(top_o === m[0], req, top_o, m[0]);
  endtask

  initial begin
    int unsigned cyc = 0;
    while (cyc < 150000) begin @(posedge clk_i); cyc++; end
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [8:0] exp_seq [4];
    void'($urandom(32'h5eed_1234));
    m[0] = 0; m[1] = 0; m[2] = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: reset state
    check(top_o === 9'h000, "R1 reset top", top_o, 9'h000);
    op(0, 1, 9'h0AA, "R1 pop after reset");
    op(0, 1, 9'h055, "R1 second pop after reset");

    // R6/R3/R5: four pushes, four pops
    op(1, 0, 9'h011, "R3 push A1");
    op(1, 0, 9'h022, "R3 push A2");
    op(1, 0, 9'h033, "R3 push A3");
    op(1, 0, 9'h044, "R3 push A4 overflow");
    exp_seq = '{9'h044, 9'h033, 9'h022, 9'h022};
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      pop_i = 1; #1;
      check(top_o === exp_seq[i], "R6 pop order", top_o, exp_seq[i]);
      model_step(0, 1, 0);
      @(negedge clk_i); pop_i = 0;
      check(top_o === m[0], "R4/R5 after pop", top_o, m[0]);
    end
    op(0, 1, 9'h000, "R5 extra pop repeats deepest");

    // R7: combined push/pop
    op(1, 0, 9'h101, "R3 push");
    op(1, 0, 9'h102, "R3 push");
    op(1, 0, 9'h103, "R3 push");
    op(1, 1, 9'h1F0, "R7 swap top");
    op(0, 1, 0, "R7 pop below swap");
    check(top_o === 9'h102, "R7 level1 unchanged", top_o, 9'h102);
    op(0, 1, 0, "R7 pop");
    check(top_o === 9'h101, "R7 level2 unchanged", top_o, 9'h101);

    // R8: idle with changing address
    op(1, 0, 9'h0C3, "R3 push");
    for (int i = 0; i < 5; i++) op(0, 0, 9'(i * 77 + 5), "R8 idle hold");
    check(top_o === 9'h0C3, "R8 top held", top_o, 9'h0C3);

    // R9: extremes
    op(1, 0, 9'h1FF, "R9 push all ones");
    op(1, 0, 9'h000, "R9 push zero");
    op(0, 1, 0, "R9 pop zero");
    check(top_o === 9'h1FF, "R9 all ones kept", top_o, 9'h1FF);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      bit pu = 1'($urandom);
      bit po = 1'($urandom);
      op(pu, po, 9'($urandom), "R3/R4/R7/R8 random");
    end

    // R1: reset mid-run
    @(negedge clk_i); rst_ni = 0; #1;
    check(top_o === 9'h000, "R1 async reset", top_o, 9'h000);
    m[0] = 0; m[1] = 0; m[2] = 0;
    @(negedge clk_i); rst_ni = 1;
    op(0, 1, 0, "R1 pop after mid reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule